// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block holds the state that a processor core reaches through its system control coprocessor. The state covers the identification word, the control word with its enable bits, the translation table base, the domain access word, the fault status and fault address, and the process ID. The core sends one move request at a time. Each request carries two opcode fields, a primary register number, a secondary register number, a direction bit and a 32-bit data word. The block sends back one response that holds read data and an error flag.

Writes to the cache-maintenance and TLB-maintenance numbers hold no state. Each one becomes a one-cycle command pulse to the caches or TLBs outside the block. The bits of the control word are also driven out as separate enable pins, so the memory system can watch them directly.

Requests and responses use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and stays stable until `rsp_ready` is high. `req_ready` is high exactly when no response is waiting or the waiting one is being taken in the same cycle. A stalled consumer therefore holds off new requests.

Top module: `sysctl_regfile`

## Requirements
- R1: A request with a nonzero `req_opc1` gets a response with `rsp_err`=1 and `rsp_data`=0, and no register changes.
- R2: Register number 0 reads back the parameter `ID_VALUE`. A write to it gets `rsp_err`=1 and leaves all state unchanged.
- R3: Register number 1 is a 32-bit read/write control word. The enable outputs follow its bits: `ctl_mmu_en` bit 0, `ctl_align_en` bit 1, `ctl_dcache_en` bit 2, `ctl_wbuf_en` bit 3, `ctl_big_endian` bit 7, `ctl_icache_en` bit 12.
- R4: Register number 2 stores the write data with bits 13:0 forced to zero, and reads them back as zero. A legal write with any of those bits set returns `rsp_warn`=1. Any other response returns `rsp_warn`=0.
- R5: Register numbers 3 and 6 are plain 32-bit read/write registers.
- R6: Register number 5 keeps only bits 7:0 of the write data. It reads back with bits 31:8 equal to zero.
- R7: Reads of register numbers 7 and 8 return `rsp_err`=1. A write to register number 7 raises `cache_op` for exactly one cycle. That cycle is the one in which the write's response first appears, and it carries the write data, `req_crm` and `req_opc2`.
- R8: A write to register number 8 with `req_opc2`=0 pulses `tlb_inv_all` for one cycle. With any other `req_opc2` it pulses `tlb_inv_va` instead, with the write data on `tlb_inv_addr`. At most one of the command pulses is high in any cycle.
- R9: Register number 13 (process ID) is read/write only when `req_opc2`=0 and `req_crm`=0. Any other encoding returns `rsp_err`=1 and the register keeps its value.
- R10: Register numbers 4, 9 to 12, 14 and 15 return `rsp_err`=1 and change nothing.
- R11: A synchronous reset clears every writable register and every enable output to 0, and leaves `rsp_valid` at 0.
- R12: `req_read`=1 means a read. The response to a request taken at edge k is valid after edge k. Write responses and error responses carry `rsp_data`=0. A response that is held by `rsp_ready`=0 stays stable, and `req_ready` is low while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_read | input | 1 | 1 = read from the coprocessor, 0 = write |
| req_opc1 | input | 3 | First opcode field, must be 0 |
| req_opc2 | input | 3 | Second opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | DATA_W | Read data |
| rsp_err | output | 1 | Illegal access |
| rsp_warn | output | 1 | Base write had nonzero low bits |
| ctl_mmu_en | output | 1 | Control bit 0 |
| ctl_align_en | output | 1 | Control bit 1 |
| ctl_dcache_en | output | 1 | Control bit 2 |
| ctl_wbuf_en | output | 1 | Control bit 3 |
| ctl_big_endian | output | 1 | Control bit 7 |
| ctl_icache_en | output | 1 | Control bit 12 |
| cache_op | output | 1 | Cache command pulse |
| cache_crm | output | 4 | Cache command secondary number |
| cache_opc2 | output | 3 | Cache command opcode2 |
| cache_data | output | DATA_W | Cache command operand |
| tlb_inv_all | output | 1 | Invalidate-all pulse |
| tlb_inv_va | output | 1 | Invalidate-by-address pulse |
| tlb_inv_addr | output | DATA_W | Address for invalidate-by-address |

## Verification
The bench builds the block with `ID_VALUE` set to 32'hC0DE_0017 and keeps the default 32-bit width, 14-bit table alignment and 8-bit fault status. The identification value has bits set in both halves and in the low nibble, so a read that returns a hard-coded or masked word does not match it. Because the width and masks are at their defaults, the fixed bit positions of the control enables and the 16 KB base alignment can be checked against literal values.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [3:0] {
    SEL_NONE  = 4'd0,
    SEL_ID    = 4'd1,
    SEL_CTL   = 4'd2,
    SEL_TTB   = 4'd3,
    SEL_DAC   = 4'd4,
    SEL_FSR   = 4'd5,
    SEL_FAR   = 4'd6,
    SEL_CACHE = 4'd7,
    SEL_TLB   = 4'd8,
    SEL_PID   = 4'd9
  } sel_e;

  typedef struct packed {
    sel_e sel;
    logic legal;
  } dec_t;

  localparam int CTL_MMU_BIT   = 0;
  localparam int CTL_ALIGN_BIT = 1;
  localparam int CTL_DC_BIT    = 2;
  localparam int CTL_WB_BIT    = 3;
  localparam int CTL_BE_BIT    = 7;
  localparam int CTL_IC_BIT    = 12;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int OPC_W = 3,
  parameter int CR_W  = 4
) (
  input  logic             is_read,
  input  logic [OPC_W-1:0] opc1,
  input  logic [OPC_W-1:0] opc2,
  input  logic [CR_W-1:0]  crn,
  input  logic [CR_W-1:0]  crm,
  output dec_t             dec
);

  always_comb begin
    dec.sel   = SEL_NONE;
    dec.legal = 1'b0;
    if (opc1 == '0) begin
      unique case (crn)
        CR_W'(0): begin dec.sel = SEL_ID;  dec.legal = is_read;  end
        CR_W'(1): begin dec.sel = SEL_CTL; dec.legal = 1'b1;     end
        CR_W'(2): begin dec.sel = SEL_TTB; dec.legal = 1'b1;     end
        CR_W'(3): begin dec.sel = SEL_DAC; dec.legal = 1'b1;     end
        CR_W'(5): begin dec.sel = SEL_FSR; dec.legal = 1'b1;     end
        CR_W'(6): begin dec.sel = SEL_FAR; dec.legal = 1'b1;     end
        CR_W'(7): begin dec.sel = SEL_CACHE; dec.legal = !is_read; end
        CR_W'(8): begin dec.sel = SEL_TLB; dec.legal = !is_read; end
        CR_W'(13): begin
          dec.sel   = SEL_PID;
          dec.legal = (opc2 == '0) && (crm == '0);
        end
        default: begin dec.sel = SEL_NONE; dec.legal = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = '0,
  parameter int                TTB_LOW  = 14,
  parameter int                FSR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctl_word,
  output logic              ttb_low_set
);

  localparam logic [DATA_W-1:0] TTB_MASK = {{(DATA_W-TTB_LOW){1'b1}}, {TTB_LOW{1'b0}}};
  localparam int                FSR_PAD  = DATA_W - FSR_W;

  logic [DATA_W-1:0] ctl_q, ttb_q, dac_q, far_q, pid_q;
  logic [FSR_W-1:0]  fsr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ttb_q <= '0;
      dac_q <= '0;
      far_q <= '0;
      pid_q <= '0;
      fsr_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CTL: ctl_q <= wdata;
        SEL_TTB: ttb_q <= wdata & TTB_MASK;
        SEL_DAC: dac_q <= wdata;
        SEL_FSR: fsr_q <= wdata[FSR_W-1:0];
        SEL_FAR: far_q <= wdata;
        SEL_PID: pid_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ID:  rdata = ID_VALUE;
      SEL_CTL: rdata = ctl_q;
      SEL_TTB: rdata = ttb_q;
      SEL_DAC: rdata = dac_q;
      SEL_FSR: rdata = {{FSR_PAD{1'b0}}, fsr_q};
      SEL_FAR: rdata = far_q;
      SEL_PID: rdata = pid_q;
      default: rdata = '0;
    endcase
  end

  assign ctl_word    = ctl_q;
  assign ttb_low_set = |wdata[TTB_LOW-1:0];

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OPC_W  = 3,
  parameter int CR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  sel_e              sel,
  input  logic [OPC_W-1:0]  opc2,
  input  logic [CR_W-1:0]   crm,
  input  logic [DATA_W-1:0] wdata,
  output logic              cache_op,
  output logic [CR_W-1:0]   cache_crm,
  output logic [OPC_W-1:0]  cache_opc2,
  output logic [DATA_W-1:0] cache_data,
  output logic              inv_all,
  output logic              inv_va,
  output logic [DATA_W-1:0] inv_addr
);

  logic cache_hit, tlb_hit;

  assign cache_hit = fire && (sel == SEL_CACHE);
  assign tlb_hit   = fire && (sel == SEL_TLB);

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_op   <= 1'b0;
      cache_crm  <= '0;
      cache_opc2 <= '0;
      cache_data <= '0;
      inv_all    <= 1'b0;
      inv_va     <= 1'b0;
      inv_addr   <= '0;
    end else begin
      cache_op <= cache_hit;
      inv_all  <= tlb_hit && (opc2 == '0);
      inv_va   <= tlb_hit && (opc2 != '0);
      if (cache_hit) begin
        cache_crm  <= crm;
        cache_opc2 <= opc2;
        cache_data <= wdata;
      end
      if (tlb_hit) inv_addr <= wdata;
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h4100_0000,
  parameter int          TTB_LOW  = 14,
  parameter int          FSR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic [2:0]        req_opc1,
  input  logic [2:0]        req_opc2,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              rsp_warn,
  output logic              ctl_mmu_en,
  output logic              ctl_align_en,
  output logic              ctl_dcache_en,
  output logic              ctl_wbuf_en,
  output logic              ctl_big_endian,
  output logic              ctl_icache_en,
  output logic              cache_op,
  output logic [3:0]        cache_crm,
  output logic [2:0]        cache_opc2,
  output logic [DATA_W-1:0] cache_data,
  output logic              tlb_inv_all,
  output logic              tlb_inv_va,
  output logic [DATA_W-1:0] tlb_inv_addr
);

  localparam int OPC_W = 3;
  localparam int CR_W  = 4;
  localparam logic [DATA_W-1:0] ID_W = DATA_W'(ID_VALUE);

  dec_t              dec;
  logic              accept, wr_fire;
  logic [DATA_W-1:0] rd_word, ctl_word;
  logic              low_set;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_fire   = accept && dec.legal && !req_read;

  sysctl_decode #(.OPC_W(OPC_W), .CR_W(CR_W)) u_decode (
    .is_read (req_read),
    .opc1    (req_opc1),
    .opc2    (req_opc2),
    .crn     (req_crn),
    .crm     (req_crm),
    .dec     (dec)
  );

  sysctl_regs #(
    .DATA_W  (DATA_W),
    .ID_VALUE(ID_W),
    .TTB_LOW (TTB_LOW),
    .FSR_W   (FSR_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_fire),
    .sel        (dec.sel),
    .wdata      (req_wdata),
    .rdata      (rd_word),
    .ctl_word   (ctl_word),
    .ttb_low_set(low_set)
  );

  sysctl_cmd #(.DATA_W(DATA_W), .OPC_W(OPC_W), .CR_W(CR_W)) u_cmd (
    .clk       (clk),
    .rst       (rst),
    .fire      (wr_fire),
    .sel       (dec.sel),
    .opc2      (req_opc2),
    .crm       (req_crm),
    .wdata     (req_wdata),
    .cache_op  (cache_op),
    .cache_crm (cache_crm),
    .cache_opc2(cache_opc2),
    .cache_data(cache_data),
    .inv_all   (tlb_inv_all),
    .inv_va    (tlb_inv_va),
    .inv_addr  (tlb_inv_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_warn  <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= !dec.legal;
      rsp_data  <= (dec.legal && req_read) ? rd_word : '0;
      rsp_warn  <= wr_fire && (dec.sel == SEL_TTB) && low_set;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      rsp_warn  <= 1'b0;
    end
  end

  assign ctl_mmu_en     = ctl_word[CTL_MMU_BIT];
  assign ctl_align_en   = ctl_word[CTL_ALIGN_BIT];
  assign ctl_dcache_en  = ctl_word[CTL_DC_BIT];
  assign ctl_wbuf_en    = ctl_word[CTL_WB_BIT];
  assign ctl_big_endian = ctl_word[CTL_BE_BIT];
  assign ctl_icache_en  = ctl_word[CTL_IC_BIT];

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_read,
  input logic [2:0]        req_opc1,
  input logic [3:0]        req_crn,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err,
  input logic              rsp_warn,
  input logic              cache_op,
  input logic              tlb_inv_all,
  input logic              tlb_inv_va
);

  logic took, fsr_rd_q, ttb_rd_q;

  assign took = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_rd_q <= 1'b0;
      ttb_rd_q <= 1'b0;
    end else if (took) begin
      fsr_rd_q <= req_read && req_opc1 == 3'd0 && req_crn == 4'd5;
      ttb_rd_q <= req_read && req_opc1 == 3'd0 && req_crn == 4'd2;
    end
  end

  AST_OPC1_ERR: assert property (@(posedge clk) disable iff (rst)
    took && req_opc1 != 3'd0 |=> rsp_valid && rsp_err && rsp_data == '0); // R1

  AST_ID_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
    took && !req_read && req_crn == 4'd0 |=> rsp_valid && rsp_err); // R2

  AST_TTB_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && ttb_rd_q |-> rsp_data[13:0] == 14'd0); // R4

  AST_WARN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_warn |-> rsp_valid && !rsp_err); // R4

  AST_FSR_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && fsr_rd_q |-> rsp_data[DATA_W-1:8] == '0); // R6

  AST_PULSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cache_op || tlb_inv_all || tlb_inv_va) |-> rsp_valid && !rsp_err); // R7

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cache_op, tlb_inv_all, tlb_inv_va})); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err)); // R12

  AST_READY_RULE: assert property (@(posedge clk) disable iff (rst)
    req_ready == (!rsp_valid || rsp_ready)); // R12

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_read   (req_read),
  .req_opc1   (req_opc1),
  .req_crn    (req_crn),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_err    (rsp_err),
  .rsp_warn   (rsp_warn),
  .cache_op   (cache_op),
  .tlb_inv_all(tlb_inv_all),
  .tlb_inv_va (tlb_inv_va)
);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID_TB      = 32'hC0DE_0017;
  localparam int          NVEC       = 27;

  typedef struct packed {
    logic        rd;
    logic [2:0]  o1;
    logic [2:0]  o2;
    logic [3:0]  n;
    logic [3:0]  m;
    logic [31:0] wd;
    logic [31:0] ed;
    logic        ee;
    logic        ew;
    logic [3:0]  rq;
  } vec_t;

  // rd, opc1, opc2, crn, crm, wdata, exp data, exp err, exp warn, requirement
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd0, 3'd0, 4'd0,  4'd0, 32'h0,         ID_TB,         1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 3'd0, 3'd0, 4'd0,  4'd0, 32'h5,         32'h0,         1'b1, 1'b0, 4'd2},  // R2
    '{1'b1, 3'd0, 3'd0, 4'd0,  4'd0, 32'h0,         ID_TB,         1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 3'd0, 3'd0, 4'd1,  4'd0, 32'h0000_1085, 32'h0,         1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 3'd0, 3'd0, 4'd1,  4'd0, 32'h0,         32'h0000_1085, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b0, 3'd0, 3'd0, 4'd2,  4'd0, 32'hABCD_FFFF, 32'h0,         1'b0, 1'b1, 4'd4},  // R4
    '{1'b1, 3'd0, 3'd0, 4'd2,  4'd0, 32'h0,         32'hABCD_C000, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 3'd0, 3'd0, 4'd2,  4'd0, 32'h1234_4000, 32'h0,         1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 3'd0, 3'd0, 4'd2,  4'd0, 32'h0,         32'h1234_4000, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 3'd0, 3'd0, 4'd3,  4'd0, 32'h5555_AAAA, 32'h0,         1'b0, 1'b0, 4'd5},  // R5
    '{1'b1, 3'd0, 3'd0, 4'd3,  4'd0, 32'h0,         32'h5555_AAAA, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b0, 3'd0, 3'd0, 4'd6,  4'd0, 32'hDEAD_BEEF, 32'h0,         1'b0, 1'b0, 4'd5},  // R5
    '{1'b1, 3'd0, 3'd0, 4'd6,  4'd0, 32'h0,         32'hDEAD_BEEF, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b0, 3'd0, 3'd0, 4'd5,  4'd0, 32'h1234_56A5, 32'h0,         1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 3'd0, 3'd0, 4'd5,  4'd0, 32'h0,         32'h0000_00A5, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 3'd0, 3'd0, 4'd13, 4'd0, 32'h0000_0042, 32'h0,         1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 3'd0, 3'd0, 4'd13, 4'd0, 32'h0,         32'h0000_0042, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b0, 3'd0, 3'd1, 4'd13, 4'd0, 32'h0000_0099, 32'h0,         1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 3'd0, 3'd0, 4'd13, 4'd1, 32'h0000_0077, 32'h0,         1'b1, 1'b0, 4'd9},  // R9
    '{1'b1, 3'd0, 3'd0, 4'd13, 4'd0, 32'h0,         32'h0000_0042, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 3'd0, 3'd0, 4'd7,  4'd0, 32'h0,         32'h0,         1'b1, 1'b0, 4'd7},  // R7
    '{1'b1, 3'd0, 3'd0, 4'd8,  4'd0, 32'h0,         32'h0,         1'b1, 1'b0, 4'd7},  // R7
    '{1'b0, 3'd0, 3'd0, 4'd15, 4'd0, 32'h1,         32'h0,         1'b1, 1'b0, 4'd10}, // R10
    '{1'b1, 3'd0, 3'd0, 4'd4,  4'd0, 32'h0,         32'h0,         1'b1, 1'b0, 4'd10}, // R10
    '{1'b0, 3'd2, 3'd0, 4'd3,  4'd0, 32'h0,         32'h0,         1'b1, 1'b0, 4'd1},  // R1
    '{1'b1, 3'd0, 3'd0, 4'd3,  4'd0, 32'h0,         32'h5555_AAAA, 1'b0, 1'b0, 4'd1},  // R1
    '{1'b1, 3'd1, 3'd0, 4'd1,  4'd0, 32'h0,         32'h0,         1'b1, 1'b0, 4'd1}   // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_read = 1'b0, rsp_ready = 1'b1;
  logic [2:0]  req_opc1 = '0, req_opc2 = '0;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, rsp_warn;
  logic [31:0] rsp_data, cache_data, tlb_inv_addr;
  logic        ctl_mmu_en, ctl_align_en, ctl_dcache_en, ctl_wbuf_en, ctl_big_endian, ctl_icache_en;
  logic        cache_op, tlb_inv_all, tlb_inv_va;
  logic [3:0]  cache_crm;
  logic [2:0]  cache_opc2;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile #(.ID_VALUE(ID_TB)) u_sysctl_regfile (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_opc1(req_opc1), .req_opc2(req_opc2), .req_crn(req_crn), .req_crm(req_crm),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .rsp_warn(rsp_warn),
    .ctl_mmu_en(ctl_mmu_en), .ctl_align_en(ctl_align_en), .ctl_dcache_en(ctl_dcache_en),
    .ctl_wbuf_en(ctl_wbuf_en), .ctl_big_endian(ctl_big_endian), .ctl_icache_en(ctl_icache_en),
    .cache_op(cache_op), .cache_crm(cache_crm), .cache_opc2(cache_opc2), .cache_data(cache_data),
    .tlb_inv_all(tlb_inv_all), .tlb_inv_va(tlb_inv_va), .tlb_inv_addr(tlb_inv_addr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge take it, return at the next falling edge.
  task automatic send(input logic rd, input logic [2:0] o1, input logic [2:0] o2,
                      input logic [3:0] n, input logic [3:0] m, input logic [31:0] wd);
    req_read  = rd;
    req_opc1  = o1;
    req_opc2  = o2;
    req_crn   = n;
    req_crm   = m;
    req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: state right after reset
    check("R11", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11", "req_ready", 32'(req_ready), 32'd1);
    check("R11", "ctl outputs",
          32'({ctl_icache_en, ctl_big_endian, ctl_wbuf_en, ctl_dcache_en, ctl_align_en, ctl_mmu_en}), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      send(VECS[i].rd, VECS[i].o1, VECS[i].o2, VECS[i].n, VECS[i].m, VECS[i].wd);
      check($sformatf("R%0d", VECS[i].rq), $sformatf("vec%0d valid", i), 32'(rsp_valid), 32'd1);
      check($sformatf("R%0d", VECS[i].rq), $sformatf("vec%0d data", i), rsp_data, VECS[i].ed);
      check($sformatf("R%0d", VECS[i].rq), $sformatf("vec%0d err", i), 32'(rsp_err), 32'(VECS[i].ee));
      check($sformatf("R%0d", VECS[i].rq), $sformatf("vec%0d warn", i), 32'(rsp_warn), 32'(VECS[i].ew));
    end

    // R3: enable outputs follow bits 12,7,3,2,1,0
    send(1'b0, 3'd0, 3'd0, 4'd1, 4'd0, 32'h0000_108A);
    check("R3", "ctl enables 108A",
          32'({ctl_icache_en, ctl_big_endian, ctl_wbuf_en, ctl_dcache_en, ctl_align_en, ctl_mmu_en}), 32'b111010);
    send(1'b0, 3'd0, 3'd0, 4'd1, 4'd0, 32'h0000_0005);
    check("R3", "ctl enables 0005",
          32'({ctl_icache_en, ctl_big_endian, ctl_wbuf_en, ctl_dcache_en, ctl_align_en, ctl_mmu_en}), 32'b000101);

    // R8: invalidate-all pulse
    send(1'b0, 3'd0, 3'd0, 4'd8, 4'd0, 32'h0);
    check("R8", "inv_all pulse", 32'({tlb_inv_all, tlb_inv_va, cache_op}), 32'b100);
    @(negedge clk);
    check("R8", "inv_all drops", 32'({tlb_inv_all, tlb_inv_va, cache_op}), 32'b000);
    // R8: invalidate-by-address pulse
    send(1'b0, 3'd0, 3'd3, 4'd8, 4'd0, 32'h8000_1000);
    check("R8", "inv_va pulse", 32'({tlb_inv_all, tlb_inv_va, cache_op}), 32'b010);
    check("R8", "inv_va addr", tlb_inv_addr, 32'h8000_1000);
    @(negedge clk);
    check("R8", "inv_va drops", 32'({tlb_inv_all, tlb_inv_va, cache_op}), 32'b000);
    // R7: cache command pulse
    send(1'b0, 3'd0, 3'd4, 4'd7, 4'd5, 32'h0000_0077);
    check("R7", "cache pulse", 32'({tlb_inv_all, tlb_inv_va, cache_op}), 32'b001);
    check("R7", "cache fields", {21'd0, cache_opc2, cache_crm, 4'd0}, {21'd0, 3'd4, 4'd5, 4'd0});
    check("R7", "cache data", cache_data, 32'h0000_0077);
    check("R7", "cache rsp ok", 32'(rsp_err), 32'd0);
    @(negedge clk);
    check("R7", "cache drops", 32'(cache_op), 32'd0);

    // R12: back-pressure holds response and request
    rsp_ready = 1'b0;
    send(1'b1, 3'd0, 3'd0, 4'd3, 4'd0, 32'h0);
    req_read = 1'b1; req_crn = 4'd6; req_valid = 1'b1;
    check("R12", "ready low while held", 32'(req_ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R12", "held valid", 32'(rsp_valid), 32'd1);
    check("R12", "held data", rsp_data, 32'h5555_AAAA);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12", "next data", rsp_data, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R12", "drained", 32'(rsp_valid), 32'd0);

    // R11: reset clears writable state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", "ctl after reset",
          32'({ctl_icache_en, ctl_big_endian, ctl_wbuf_en, ctl_dcache_en, ctl_align_en, ctl_mmu_en}), 32'd0);
    send(1'b1, 3'd0, 3'd0, 4'd3, 4'd0, 32'h0);
    check("R11", "dac after reset", rsp_data, 32'h0);
    send(1'b1, 3'd0, 3'd0, 4'd13, 4'd0, 32'h0);
    check("R11", "pid after reset", rsp_data, 32'h0);
    send(1'b1, 3'd0, 3'd0, 4'd2, 4'd0, 32'h0);
    check("R11", "ttb after reset", rsp_data, 32'h0);
    send(1'b1, 3'd0, 3'd0, 4'd0, 4'd0, 32'h0);
    check("R2", "id after reset", rsp_data, ID_TB);

    @(negedge clk);
    finish_run();
  end

endmodule